// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a two-port word memory and watches both access ports. When the left and right ports are both enabled and present the same word address in the same cycle, it lets one of them proceed and raises an active-low busy indication toward the other. While a port is held busy, the block suppresses that port's write strobe toward the memory array. Reads from the busy port still reach the array unchanged. The decision depends only on the enables and the addresses. Whether either access is a read or a write plays no part in it.

The block runs in one of two roles, chosen by a mode input. As the master it makes the decision and drives the busy outputs to a definite level at all times. As a slave it makes no decision of its own. It takes external busy inputs, usually driven by one master in a width-expanded array, and uses them only to suppress writes. Because every slice of a wide word follows the same single decision, no word is ever written partly from one port and partly from the other.

When both ports reach the shared address together, a fixed tie-break picks the winner. A port that was already parked on the address when the other port arrived wins instead. The winner keeps its priority until the collision ends.

Top module: `dpb_arbiter`

## Requirements
- R1: A collision is a cycle in which both enables are high and the two addresses are equal. In master mode a busy output (active low, 0 = busy) goes low only on the clock edge that ends a collision cycle. Both busy outputs return high on the edge that ends the first cycle without a collision.
- R2: When a collision begins and both ports arrived at the address together, the left port wins. The right busy output goes low and the left one stays high.
- R3: When a collision begins and only one port held the same enabled address in the previous cycle, that port wins and the newcomer is flagged busy.
- R4: While the collision continues without a break, the winner keeps priority, even if both ports move together to a new shared address.
- R5: In master mode the losing port's gated write strobe is 0 in every cycle of the collision, starting with the first. The winner's write strobe is its enable AND its write request.
- R6: The read/write direction of either access does not change which port wins. A port that requests no write never produces a gated write strobe.
- R7: In slave mode both busy outputs stay high. A port's gated write strobe follows its enable AND its write request when that port's busy input is 1. It is 0 when that port's busy input is 0.
- R8: In master mode the busy inputs have no effect on the gated write strobes.
- R9: After reset both busy outputs are high and no port holds priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1 = master (decides and drives busy), 0 = slave (busy inputs inhibit writes) |
| lt_en | input | 1 | Left port enable |
| lt_addr | input | ADDR_W | Left port word address |
| lt_we | input | 1 | Left port write request |
| lt_busy_n_i | input | 1 | Left write-inhibit input, active low, used in slave mode |
| lt_busy_n_o | output | 1 | Left busy output, active low |
| lt_we_o | output | 1 | Left gated write strobe toward the array |
| rt_en | input | 1 | Right port enable |
| rt_addr | input | ADDR_W | Right port word address |
| rt_we | input | 1 | Right port write request |
| rt_busy_n_i | input | 1 | Right write-inhibit input, active low, used in slave mode |
| rt_busy_n_o | output | 1 | Right busy output, active low |
| rt_we_o | output | 1 | Right gated write strobe toward the array |

## Verification
The assertions check on every cycle that busy only follows a collision and always clears after one, that the two busy outputs are never low together, that a busy port never writes in master mode or while its inhibit input is low in slave mode, that slave busy outputs stay high, and that a winner keeps priority through a continued collision. Which port wins at the start of a collision depends on how each port arrived: together or one after the other. Only the bench's scenarios and its cycle-by-cycle reference model can show that choice. The same holds for the winner surviving a joint move to a new address, and for the first-cycle write suppression of the loser.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NPORT   = 2;
   localparam int PORT_LT = 0;
   localparam int PORT_RT = 1;
endpackage

// File: rtl/dpb_port_track.sv
module dpb_port_track #(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              stay
);
   logic              prev_en_q;
   logic [ADDR_W-1:0] prev_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en_q   <= 1'b0;
         prev_addr_q <= '0;
      end else begin
         prev_en_q   <= en;
         prev_addr_q <= addr;
      end
   end

   // port held the same enabled address in the previous cycle
   assign stay = en & prev_en_q & (addr == prev_addr_q);
endmodule

// File: rtl/dpb_collide_cmp.sv
module dpb_collide_cmp #(
   parameter int ADDR_W  = 15,
   parameter int SLICE_W = 0
) (
   input  logic              en_l,
   input  logic              en_r,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   output logic              hit
);
   logic addr_eq;

   generate
      if (SLICE_W <= 0) begin : g_flat
         assign addr_eq = (addr_l == addr_r);
      end else begin : g_sliced
         localparam int NSLICE = (ADDR_W + SLICE_W - 1) / SLICE_W;
         logic [NSLICE-1:0] slice_eq;
         for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            logic [SLICE_W-1:0] diff;
            for (genvar b = 0; b < SLICE_W; b++) begin : g_bit
               if (s * SLICE_W + b < ADDR_W) begin : g_live
                  assign diff[b] = addr_l[s*SLICE_W+b] ^ addr_r[s*SLICE_W+b];
               end else begin : g_pad
                  assign diff[b] = 1'b0;
               end
            end
            assign slice_eq[s] = ~|diff;
         end
         assign addr_eq = &slice_eq;
      end
   endgenerate

   assign hit = en_l & en_r & addr_eq;
endmodule

// File: rtl/dpb_owner_fsm.sv
module dpb_owner_fsm
   import dpb_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   hit,
   input  logic   stay_l,
   input  logic   stay_r,
   output owner_e owner_q,
   output owner_e owner_d
);
   owner_e tie_pick;
   owner_e fresh;

   generate
      if (TIE_LEFT) begin : g_tie_l
         assign tie_pick = OWN_LEFT;
      end else begin : g_tie_r
         assign tie_pick = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      if (stay_r && !stay_l)      fresh = OWN_RIGHT;
      else if (stay_l && !stay_r) fresh = OWN_LEFT;
      else                        fresh = tie_pick;
   end

   always_comb begin
      if (!hit)                   owner_d = OWN_NONE;
      else if (owner_q != OWN_NONE) owner_d = owner_q;
      else                        owner_d = fresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end
endmodule

// File: rtl/dpb_wr_gate.sv
module dpb_wr_gate (
   input  logic master,
   input  logic en,
   input  logic we,
   input  logic lose_now,
   input  logic busy_n_in,
   output logic we_o
);
   logic allow;
   assign allow = master ? ~lose_now : busy_n_in;
   assign we_o  = en & we & allow;
endmodule

// File: rtl/dpb_arbiter.sv
module dpb_arbiter
   import dpb_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int SLICE_W  = 0,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic              lt_en,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_we,
   input  logic              lt_busy_n_i,
   output logic              lt_busy_n_o,
   output logic              lt_we_o,
   input  logic              rt_en,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_we,
   input  logic              rt_busy_n_i,
   output logic              rt_busy_n_o,
   output logic              rt_we_o
);
   generate
      if (ADDR_W < 1)       begin : g_bad_aw  $error("ADDR_W must be at least 1"); end
      if (SLICE_W > ADDR_W) begin : g_bad_sw  $error("SLICE_W must not exceed ADDR_W"); end
   endgenerate

   logic [ADDR_W-1:0] p_addr [NPORT];
   logic [NPORT-1:0]  p_en, p_we, p_bin, p_stay, p_lose, p_weo;
   logic              hit;
   owner_e            owner_q, owner_d;

   assign p_addr[PORT_LT] = lt_addr;
   assign p_addr[PORT_RT] = rt_addr;
   assign p_en  = {rt_en, lt_en};
   assign p_we  = {rt_we, lt_we};
   assign p_bin = {rt_busy_n_i, lt_busy_n_i};

   dpb_collide_cmp #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_cmp (
      .en_l(lt_en), .en_r(rt_en), .addr_l(lt_addr), .addr_r(rt_addr), .hit(hit)
   );

   dpb_owner_fsm #(.TIE_LEFT(TIE_LEFT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .hit(hit),
      .stay_l(p_stay[PORT_LT]), .stay_r(p_stay[PORT_RT]),
      .owner_q(owner_q), .owner_d(owner_d)
   );

   assign p_lose[PORT_LT] = hit & (owner_d == OWN_RIGHT);
   assign p_lose[PORT_RT] = hit & (owner_d == OWN_LEFT);

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dpb_port_track #(.ADDR_W(ADDR_W)) u_trk (
         .clk(clk), .rst_n(rst_n), .en(p_en[p]), .addr(p_addr[p]), .stay(p_stay[p])
      );
      dpb_wr_gate u_gate (
         .master(master_sel), .en(p_en[p]), .we(p_we[p]),
         .lose_now(p_lose[p]), .busy_n_in(p_bin[p]), .we_o(p_weo[p])
      );
   end

   assign lt_we_o     = p_weo[PORT_LT];
   assign rt_we_o     = p_weo[PORT_RT];
   assign lt_busy_n_o = ~(master_sel & (owner_q == OWN_RIGHT));
   assign rt_busy_n_o = ~(master_sel & (owner_q == OWN_LEFT));

   // R1: busy clears after a non-collision cycle
   a_r1_clear_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (lt_busy_n_o && rt_busy_n_o));
   // R1: a master collision raises exactly one busy
   a_r1_busy_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && hit) |=> (!master_sel || (lt_busy_n_o != rt_busy_n_o)));
   // R2: never both ports busy
   a_r2_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_busy_n_o || rt_busy_n_o));
   // R4: winner keeps priority while the collision lasts
   a_r4_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && hit && !rt_busy_n_o) |=> (!hit || !master_sel || !rt_busy_n_o));
   a_r4_keep_right: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && hit && !lt_busy_n_o) |=> (!hit || !master_sel || !lt_busy_n_o));
   // R5: a flagged port never writes during the collision
   a_r5_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && hit && !lt_busy_n_o) |-> !lt_we_o);
   a_r5_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && hit && !rt_busy_n_o) |-> !rt_we_o);
   // R6: no write request, no write strobe
   a_r6_no_spurious_we: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_we |-> !lt_we_o) and (!rt_we |-> !rt_we_o));
   // R7: slave mode busy outputs idle and inhibit inputs honoured
   a_r7_slave_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |-> (lt_busy_n_o && rt_busy_n_o));
   a_r7_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |-> ((!lt_busy_n_i |-> !lt_we_o) and (!rt_busy_n_i |-> !rt_we_o)));
endmodule

// File: tb/tb_dpb_arbiter.sv
module tb_dpb_arbiter;
   localparam int AW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_sel = 1'b1;
   logic          lt_en = 0, lt_we = 0, lt_bin = 1, rt_en = 0, rt_we = 0, rt_bin = 1;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic          lt_busy_n_o, lt_we_o, rt_busy_n_o, rt_we_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dpb_arbiter #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
      .lt_en(lt_en), .lt_addr(lt_addr), .lt_we(lt_we), .lt_busy_n_i(lt_bin),
      .lt_busy_n_o(lt_busy_n_o), .lt_we_o(lt_we_o),
      .rt_en(rt_en), .rt_addr(rt_addr), .rt_we(rt_we), .rt_busy_n_i(rt_bin),
      .rt_busy_n_o(rt_busy_n_o), .rt_we_o(rt_we_o)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 none, 1 left holds, 2 right holds
   int m_own = 0;
   int m_pl_en = 0, m_pr_en = 0;
   int m_pl_a = 0, m_pr_a = 0;

   function automatic int fresh_pick();
      bit ls, rs;
      ls = lt_en && m_pl_en != 0 && int'(lt_addr) == m_pl_a;
      rs = rt_en && m_pr_en != 0 && int'(rt_addr) == m_pr_a;
      return (rs && !ls) ? 2 : 1;
   endfunction

   function automatic bit m_coll();
      return lt_en && rt_en && lt_addr == rt_addr;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_own = 0; m_pl_en = 0; m_pr_en = 0; m_pl_a = 0; m_pr_a = 0;
      end else begin
         if (!m_coll())      m_own = 0;
         else if (m_own == 0) m_own = fresh_pick();
         m_pl_en = lt_en; m_pr_en = rt_en;
         m_pl_a = int'(lt_addr); m_pr_a = int'(rt_addr);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int win;
         bit el, er;
         win = !m_coll() ? 0 : (m_own != 0 ? m_own : fresh_pick());
         check("R1 model lt busy", lt_busy_n_o, !(master_sel && m_own == 2));
         check("R1 model rt busy", rt_busy_n_o, !(master_sel && m_own == 1));
         el = lt_en && lt_we && (master_sel ? (win != 2) : lt_bin);
         er = rt_en && rt_we && (master_sel ? (win != 1) : rt_bin);
         check("R5 model lt we", lt_we_o, el);
         check("R5 model rt we", rt_we_o, er);
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic drive(input logic le, input int la, input logic lw,
                        input logic re, input int ra, input logic rw);
      lt_en = le; lt_addr = AW'(la); lt_we = lw;
      rt_en = re; rt_addr = AW'(ra); rt_we = rw;
      #1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12;
      check("R9 lt busy in reset", lt_busy_n_o, 1'b1);
      rst_n = 1'b1;
      cyc();
      check("R9 lt busy after reset", lt_busy_n_o, 1'b1);
      check("R9 rt busy after reset", rt_busy_n_o, 1'b1);

      // R2: simultaneous arrival, both writing
      drive(1, 5, 1, 1, 5, 1);
      check("R5 winner left writes first cycle", lt_we_o, 1'b1);
      check("R5 loser right blocked first cycle", rt_we_o, 1'b0);
      cyc();
      check("R2 right busy", rt_busy_n_o, 1'b0);
      check("R2 left not busy", lt_busy_n_o, 1'b1);
      drive(1, 5, 1, 1, 6, 1);
      check("R1 busy still shown in ending cycle", rt_busy_n_o, 1'b0);
      cyc();
      check("R1 busy cleared", rt_busy_n_o, 1'b1);

      // R3: right parked first, left arrives
      drive(1, 9, 0, 1, 3, 0);
      cyc();
      drive(1, 3, 1, 1, 3, 0);
      check("R3 newcomer left blocked", lt_we_o, 1'b0);
      cyc();
      check("R3 left busy", lt_busy_n_o, 1'b0);
      check("R3 right not busy", rt_busy_n_o, 1'b1);
      // R4: both move together to another shared address
      drive(1, 7, 1, 1, 7, 1);
      check("R4 right keeps writing", rt_we_o, 1'b1);
      cyc();
      check("R4 left still busy", lt_busy_n_o, 1'b0);
      // enable released
      drive(1, 7, 0, 0, 7, 0);
      cyc();
      check("R1 cleared on enable drop", lt_busy_n_o, 1'b1);

      // R6: reads only, simultaneous arrival
      drive(0, 0, 0, 0, 0, 0);
      cyc();
      drive(1, 4, 0, 1, 4, 0);
      check("R6 read gives no strobe", lt_we_o, 1'b0);
      cyc();
      check("R6 reads arbitrate the same", rt_busy_n_o, 1'b0);
      drive(0, 0, 0, 0, 0, 0);
      cyc();

      // R8: master ignores inhibit inputs
      lt_bin = 0; rt_bin = 0;
      drive(1, 1, 1, 1, 2, 1);
      check("R8 left write passes", lt_we_o, 1'b1);
      check("R8 right write passes", rt_we_o, 1'b1);

      // R7: slave mode
      master_sel = 0;
      drive(1, 8, 1, 1, 8, 1);
      check("R7 left inhibited", lt_we_o, 1'b0);
      lt_bin = 1;
      drive(1, 8, 1, 1, 8, 1);
      check("R7 left allowed", lt_we_o, 1'b1);
      check("R7 right inhibited", rt_we_o, 1'b0);
      cyc();
      check("R7 slave lt busy high", lt_busy_n_o, 1'b1);
      check("R7 slave rt busy high", rt_busy_n_o, 1'b1);
      rt_bin = 1;
      drive(0, 0, 0, 0, 0, 0);
      cyc();

      // random traffic over a small address set, both modes
      for (int i = 0; i < 3000; i++) begin
         if (i % 500 == 0) master_sel = (i / 500) % 3 != 2;
         lt_bin = ($urandom % 4) != 0;
         rt_bin = ($urandom % 4) != 0;
         drive(($urandom % 5) != 0, $urandom % 3, $urandom % 2,
               ($urandom % 5) != 0, $urandom % 3, $urandom % 2);
         cyc();
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule